// File: doc/BRIEF.md
# CAN Receive Frame Queue

This block is a three-slot queue placed between a CAN receive engine and the host processor. Each slot holds one whole received frame: the identifier, the data length code and eight data bytes. The receive engine writes a frame with a single-cycle store strobe. The host always sees the oldest pending frame on the read ports. It discards that frame with a single-cycle release strobe.

The queue keeps a write pointer and a release pointer, plus a pending count from 0 to 3. A store and a release can fall in the same cycle at any fill level, and both pointers and the count stay consistent when they do. When all three slots are taken and a frame arrives with no release, the newest stored frame is replaced. A sticky overrun flag records the loss, and the host clears it with a one-cycle clear strobe.

Top module: `can_rxq`

## Requirements
- R1: A synchronous active-low reset empties the queue, aligns both pointers and clears the overrun flag; after reset `rd_valid`, `pend_cnt`, `full` and `overrun` are all 0.
- R2: A store while fewer than three frames are pending and no release is given adds the frame behind the others and raises `pend_cnt` by one on the next clock; frames leave in arrival order.
- R3: A release while at least one frame is pending removes the oldest frame and lowers `pend_cnt` by one on the next clock; the read ports then show the next-oldest frame.
- R4: `rd_valid` is 1 exactly when `pend_cnt` is nonzero, `full` is 1 exactly when `pend_cnt` equals 3, and the read ports always carry the oldest pending frame.
- R5: A store with no release while three frames are pending replaces the most recently stored frame; the count stays 3 and the two older frames are kept.
- R6: The store described in R5 sets `overrun`, which stays set until `ovr_clr` is 1 in a cycle with no such store; if both occur in one cycle, the flag stays set.
- R7: A store and a release in the same cycle with one or two frames pending remove the oldest, append the new frame and leave the count unchanged; with zero pending, the release is ignored and the store makes the count 1.
- R8: A store and a release in the same cycle with three frames pending remove the oldest, append the new frame as the newest, leave the count at 3 and leave `overrun` unchanged.
- R9: A release with no frame pending and no store changes no output, and the next store is the frame shown on the read ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_req | input | 1 | Single-cycle store strobe from the receive engine |
| st_id | input | 29 | Identifier of the frame being stored |
| st_dlc | input | 4 | Data length code of the frame being stored |
| st_data | input | 64 | Data bytes of the frame being stored |
| rel_cmd | input | 1 | Single-cycle release of the oldest pending frame |
| ovr_clr | input | 1 | Single-cycle clear of the overrun flag |
| rd_valid | output | 1 | A frame is pending |
| rd_id | output | 29 | Identifier of the oldest pending frame |
| rd_dlc | output | 4 | Data length code of the oldest pending frame |
| rd_data | output | 64 | Data bytes of the oldest pending frame |
| pend_cnt | output | 2 | Number of pending frames, 0 to 3 |
| full | output | 1 | Three frames are pending |
| overrun | output | 1 | Sticky: a frame was overwritten while full |

## Verification
The hardest case to reach is a store and a release in the same cycle while the queue is already full. At that point the write and release pointers sit on the same slot, and the new frame must land in the slot being freed. The stimulus fills the queue, overfills it once to set the overrun flag, and then issues coincident store and release strobes several times in a row. It then drains the queue so that every pointer position is checked. A behavioural queue model in the bench is compared with the read ports on every clock. A long random phase with a high strobe density then reaches the coincident case at every fill level and every pointer rotation.

// File: rtl/can_rxq_pkg.sv
// Package: shared frame layout for the CAN receive queue.
// Assumes standard or extended identifiers fit in ID_W bits.
package can_rxq_pkg;
    localparam int ID_W    = 29;
    localparam int DLC_W   = 4;
    localparam int NBYTES  = 8;
    localparam int DATA_W  = NBYTES * 8;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } rx_frame_t;
endpackage

// File: rtl/can_rxq_ctrl.sv
// Module: pointer and count control of the receive queue.
// Decides which slot a store writes and keeps the write pointer, the
// release pointer, the pending count and the overrun flag. Assumes
// DEPTH >= 2 and single-cycle strobes.
module can_rxq_ctrl #(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             rel,
    input  logic             clr,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx,
    output logic [CNT_W-1:0] cnt,
    output logic             ovr
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             pop, is_full, ovw;
    logic [PTR_W-1:0] newest;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    // Decode the effective operations for this cycle.
    always_comb begin
        is_full = (cnt == CNT_FULL);
        pop     = rel && (cnt != '0);
        ovw     = push && is_full && !pop;
        newest  = (wr_ptr == '0) ? PTR_LAST : wr_ptr - 1'b1;
        wr_en   = push;
        wr_idx  = ovw ? newest : wr_ptr;
        rd_idx  = rd_ptr;
    end

    // Advance the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push && !ovw) wr_ptr <= nxt(wr_ptr);
            if (pop)          rd_ptr <= nxt(rd_ptr);
            if (push && !pop && !is_full) cnt <= cnt + 1'b1;
            else if (pop && !push)        cnt <= cnt - 1'b1;
        end
    end

    // Sticky overrun flag; a new overwrite wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   ovr <= 1'b0;
        else if (ovw) ovr <= 1'b1;
        else if (clr) ovr <= 1'b0;
    end

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL);
    a_r9_empty_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (wr_ptr == rd_ptr));
    a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !rel && cnt == CNT_FULL) |=> (cnt == CNT_FULL) && $stable(wr_ptr) && $stable(rd_ptr));
    a_r6_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !rel && cnt == CNT_FULL) |=> ovr);
    a_r7_coincide: assert property (@(posedge clk) disable iff (!rst_n)
        (push && rel && cnt != '0) |=> (cnt == $past(cnt)) && (rd_ptr == nxt($past(rd_ptr))) && (wr_ptr == nxt($past(wr_ptr))));
    a_r8_full_coincide_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (push && rel && cnt == CNT_FULL && !clr) |=> $stable(ovr));
    a_r9_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !push && cnt == '0) |=> (cnt == '0) && $stable(rd_ptr));
endmodule

// File: rtl/can_rxq_store.sv
// Module: frame storage of the receive queue.
// One register per slot, written when the control selects it; the read
// side is a plain mux on the release index. Assumes wr_idx < DEPTH.
module can_rxq_store
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  rx_frame_t        wr_frame,
    input  logic [PTR_W-1:0] rd_idx,
    output rx_frame_t        rd_frame
);
    rx_frame_t slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture the incoming frame into this slot when selected.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == PTR_W'(g)) slot[g] <= wr_frame;
        end
    end

    // Present the slot at the release pointer.
    always_comb begin
        rd_frame = slot[0];
        for (int i = 1; i < DEPTH; i++)
            if (rd_idx == PTR_W'(i)) rd_frame = slot[i];
    end

    a_r5_idx_range: assert property (@(posedge clk)
        wr_en |-> (int'(wr_idx) < DEPTH));
endmodule

// File: rtl/can_rxq.sv
// Module: three-slot CAN receive frame queue (top).
// Joins pointer control and frame storage and derives the status outputs.
// Assumes store and release strobes last one cycle each.
module can_rxq
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req,
    input  logic [ID_W-1:0]   st_id,
    input  logic [DLC_W-1:0]  st_dlc,
    input  logic [DATA_W-1:0] st_data,
    input  logic              rel_cmd,
    input  logic              ovr_clr,
    output logic              rd_valid,
    output logic [ID_W-1:0]   rd_id,
    output logic [DLC_W-1:0]  rd_dlc,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  pend_cnt,
    output logic              full,
    output logic              overrun
);
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic [CNT_W-1:0] cnt;
    logic             ovr;
    rx_frame_t        in_frame, out_frame;

    // Pack the incoming fields into one frame word.
    always_comb begin
        in_frame.id   = st_id;
        in_frame.dlc  = st_dlc;
        in_frame.data = st_data;
    end

    can_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (st_req),
        .rel    (rel_cmd),
        .clr    (ovr_clr),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx),
        .cnt    (cnt),
        .ovr    (ovr)
    );

    can_rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_frame (in_frame),
        .rd_idx   (rd_idx),
        .rd_frame (out_frame)
    );

    // Drive the host-facing status and frame outputs.
    always_comb begin
        rd_valid = (cnt != '0);
        full     = (cnt == CNT_W'(DEPTH));
        pend_cnt = cnt;
        overrun  = ovr;
        rd_id    = out_frame.id;
        rd_dlc   = out_frame.dlc;
        rd_data  = out_frame.data;
    end

    a_r4_full_valid: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> rd_valid);
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (pend_cnt == '0) && !overrun);
endmodule

// File: tb/sim_can_rxq.sv
// Bench: behavioural queue model compared with the ports on every clock.
module sim_can_rxq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_req = 1'b0, rel_cmd = 1'b0, ovr_clr = 1'b0;
    logic [28:0] st_id = '0;
    logic [3:0]  st_dlc = '0;
    logic [63:0] st_data = '0;
    logic        rd_valid, full, overrun;
    logic [28:0] rd_id;
    logic [3:0]  rd_dlc;
    logic [63:0] rd_data;
    logic [1:0]  pend_cnt;

    typedef struct packed { logic [28:0] id; logic [3:0] dlc; logic [63:0] data; } frm_t;
    frm_t q[$];
    bit   m_ovr = 0;
    int   n_cmp = 0, n_bad = 0, seq = 1;
    bit   done = 0;

    always #10 clk = ~clk;

    can_rxq u0 (.clk(clk), .rst_n(rst_n), .st_req(st_req), .st_id(st_id), .st_dlc(st_dlc),
        .st_data(st_data), .rel_cmd(rel_cmd), .ovr_clr(ovr_clr), .rd_valid(rd_valid),
        .rd_id(rd_id), .rd_dlc(rd_dlc), .rd_data(rd_data), .pend_cnt(pend_cnt),
        .full(full), .overrun(overrun));

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Compare every output against the model (called away from the edge).
    task automatic check(input string tag);
        frm_t exp_f, got_f;
        int   n = q.size();
        bit   ok;
        got_f = '{rd_id, rd_dlc, rd_data};
        exp_f = (n > 0) ? q[0] : '0;
        ok = (rd_valid == (n > 0)) && (int'(pend_cnt) == n) && (full == (n == 3))
             && (overrun == m_ovr) && (n == 0 || got_f == exp_f);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got v=%0b cnt=%0d full=%0b ovr=%0b id=%h dlc=%h data=%h / exp v=%0b cnt=%0d full=%0b ovr=%0b id=%h dlc=%h data=%h",
                tag, rd_valid, pend_cnt, full, overrun, got_f.id, got_f.dlc, got_f.data,
                n > 0, n, n == 3, m_ovr, exp_f.id, exp_f.dlc, exp_f.data);
        end
    endtask

    // One cycle: check, drive, clock, update the model.
    task automatic step(input bit s, input bit r, input bit c, input string tag);
        frm_t f;
        bit   pop, set;
        @(negedge clk);
        check(tag);
        f = '{29'(seq * 7919), 4'(seq), {32'(seq), ~32'(seq)}};
        seq++;
        st_req = s; rel_cmd = r; ovr_clr = c;
        st_id = f.id; st_dlc = f.dlc; st_data = f.data;
        @(posedge clk);
        pop = r && q.size() > 0;
        set = s && q.size() == 3 && !pop;
        if (pop) void'(q.pop_front());
        if (set) q[2] = f;
        else if (s) q.push_back(f);
        if (set) m_ovr = 1;
        else if (c) m_ovr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; st_req = 0; rel_cmd = 0; ovr_clr = 0;
        repeat (3) @(posedge clk);
        q.delete(); m_ovr = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout / exp completion");
        finish_run();
    end

    initial begin
        do_reset();
        step(0, 0, 0, "R1 reset state");
        step(0, 1, 0, "R9 release while empty");
        step(0, 1, 0, "R9 release while empty");
        step(1, 1, 0, "R7 store+release at empty");
        step(1, 0, 0, "R2 store");
        step(1, 0, 0, "R2 store to full");
        step(0, 0, 0, "R4 full flag");
        step(1, 0, 0, "R5 store while full");
        step(1, 0, 1, "R6 overwrite beats clear");
        step(0, 0, 0, "R6 overrun sticky");
        for (int i = 0; i < 5; i++) step(1, 1, 0, "R8 store+release at full");
        step(0, 0, 1, "R8 overrun kept");
        step(0, 1, 0, "R6 overrun cleared");
        step(1, 1, 0, "R7 store+release at two");
        step(0, 1, 0, "R3 release");
        step(1, 1, 0, "R7 store+release at one");
        step(0, 1, 0, "R3 release to empty");
        step(0, 1, 0, "R9 release while empty");
        step(1, 0, 0, "R9 store after idle release");
        step(0, 0, 0, "R9 frame shown");
        step(1, 0, 0, "R2 store");
        step(1, 0, 0, "R2 store");
        do_reset();
        step(0, 0, 0, "R1 reset after fill");
        for (int i = 0; i < 4000; i++)
            step($urandom_range(0, 99) < 60, $urandom_range(0, 99) < 50,
                 $urandom_range(0, 99) < 10, "R4 random R7 R8 mix");
        step(0, 0, 0, "R4 final");
        done = 1;
        finish_run();
    end
endmodule